// File: doc/BRIEF.md
# Multidrop UART Address Filter

This block sits between a 9-bit serial receiver and the CPU on a shared multi-node bus. Each received character arrives with a strobe, an eight-bit payload, a flag that marks it as an address character, and a framing-error flag. The filter decides whether the character is accepted. An accepted character is written into the receive data register and raises a one-cycle interrupt pulse. A dropped character leaves the register and its status flags as they were, so traffic meant for other nodes never disturbs the CPU.

When filtering is disabled, the block behaves like a plain UART and accepts everything. When it is enabled, a two-bit policy field selects one of four behaviours. The first accepts every character and lets software follow frames through the address-flag status bit. The second accepts only address characters. The third accepts a matching address and the correctly framed data of that frame. The fourth accepts only the correctly framed data of a matched frame. A per-frame match state is evaluated again on every address character. A new-frame status bit marks the first data character delivered after a matching address. A read strobe from the CPU clears both status bits.

Top module: `mdrop_filter`

## Requirements
- R1: After reset, irq_pulse, rx_byte, is_addr_flag, new_frame_flag and frame_match are all 0.
- R2: With filt_en=0, every character strobed by rx_valid is accepted. The following cycle irq_pulse is 1, rx_byte holds the character, and is_addr_flag and new_frame_flag are 0. frame_match is 0 in every cycle after a cycle with filt_en=0.
- R3: irq_pulse is 1 only in the cycle right after an rx_valid cycle whose character is accepted. A dropped character leaves rx_byte, is_addr_flag and new_frame_flag unchanged.
- R4: With filt_en=1 and filt_mode=2'b00, every character is accepted, and is_addr_flag copies rx_is_addr.
- R5: With filt_en=1 and filt_mode=2'b01, address characters are accepted with is_addr_flag=1, and data characters are dropped.
- R6: With filt_en=1, every address character sets frame_match to 1 if its payload equals node_addr and to 0 otherwise. Data characters leave frame_match unchanged.
- R7: With filt_mode=2'b10, an address character is accepted only when it matches. A data character is accepted only while frame_match is 1, so data after a non-matching address is dropped.
- R8: With filt_mode=2'b11, address characters are never accepted. Data characters are accepted only while frame_match is 1.
- R9: In modes 2'b10 and 2'b11, a data character with rx_frame_err=1 is dropped.
- R10: In modes 2'b10 and 2'b11, new_frame_flag is 1 for the first data character accepted after a matching address and 0 for later ones.
- R11: rd_strobe clears is_addr_flag and new_frame_flag and leaves rx_byte unchanged. A character accepted in the same cycle sets its own flags instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| filt_en | input | 1 | Address filtering enable |
| filt_mode | input | 2 | Filtering policy select |
| node_addr | input | DATA_W | Address of this node |
| rx_valid | input | 1 | A received character is present this cycle |
| rx_data | input | DATA_W | Received payload |
| rx_is_addr | input | 1 | Character is an address character |
| rx_frame_err | input | 1 | Character had a framing error |
| rd_strobe | input | 1 | CPU read of the receive data register |
| irq_pulse | output | 1 | One-cycle receive interrupt |
| rx_byte | output | DATA_W | Receive data register |
| is_addr_flag | output | 1 | Delivered character was an address |
| new_frame_flag | output | 1 | Delivered character is first data of a new frame |
| frame_match | output | 1 | Current frame is addressed to this node |

## Verification
The hardest case to reach from the ports is the new-frame flag after a framing-error data character. A matching address must come first, then a bad data character that is dropped, then a good one that should still be flagged as first. On top of that, the policy may change or the enable may drop partway through the frame. The stimulus draws payloads equal to node_addr half the time and makes framing errors frequent. It changes the mode and enable only now and then, so matched frames with a bad first data character occur often in the random run. A directed sequence also builds this case explicitly.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;
    typedef enum logic [1:0] {
        POL_ALL   = 2'b00,
        POL_ADDR  = 2'b01,
        POL_MATCH = 2'b10,
        POL_DATA  = 2'b11
    } policy_e;
endpackage

// File: rtl/mdrop_addr_cmp.sv
module mdrop_addr_cmp #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] payload,
    input  logic [DATA_W-1:0] own_addr,
    output logic              hit
);
    logic [DATA_W-1:0] diff;
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign diff[i] = payload[i] ^ own_addr[i];
    end
    assign hit = ~|diff;
endmodule

// File: rtl/mdrop_policy.sv
module mdrop_policy
    import mdrop_pkg::*;
(
    input  logic    en,
    input  policy_e pol,
    input  logic    is_addr,
    input  logic    ferr,
    input  logic    hit,
    input  logic    match_q,
    input  logic    first_q,
    output logic    accept,
    output logic    flag_addr,
    output logic    flag_first,
    output logic    hw_mode
);
    always_comb begin
        accept     = 1'b1;
        flag_addr  = 1'b0;
        flag_first = 1'b0;
        hw_mode    = 1'b0;
        if (en) begin
            unique case (pol)
                POL_ALL: begin
                    accept    = 1'b1;
                    flag_addr = is_addr;
                end
                POL_ADDR: begin
                    accept    = is_addr;
                    flag_addr = is_addr;
                end
                POL_MATCH: begin
                    hw_mode    = 1'b1;
                    accept     = is_addr ? hit : (match_q && !ferr);
                    flag_addr  = is_addr;
                    flag_first = !is_addr && first_q;
                end
                POL_DATA: begin
                    hw_mode    = 1'b1;
                    accept     = !is_addr && match_q && !ferr;
                    flag_first = !is_addr && first_q;
                end
                default: accept = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/mdrop_filter.sv
module mdrop_filter
    import mdrop_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              filt_en,
    input  logic [1:0]        filt_mode,
    input  logic [DATA_W-1:0] node_addr,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_is_addr,
    input  logic              rx_frame_err,
    input  logic              rd_strobe,
    output logic              irq_pulse,
    output logic [DATA_W-1:0] rx_byte,
    output logic              is_addr_flag,
    output logic              new_frame_flag,
    output logic              frame_match
);
    typedef struct packed {
        logic              irq;
        logic [DATA_W-1:0] data;
        logic              aflag;
        logic              nflag;
        logic              match;
        logic              first;
    } state_t;

    state_t st_d, st_q;
    logic hit, accept, flag_addr, flag_first, hw_mode;
    policy_e pol;

    assign pol = policy_e'(filt_mode);

    mdrop_addr_cmp #(.DATA_W(DATA_W)) u_cmp (
        .payload (rx_data),
        .own_addr(node_addr),
        .hit     (hit)
    );

    mdrop_policy u_pol (
        .en        (filt_en),
        .pol       (pol),
        .is_addr   (rx_is_addr),
        .ferr      (rx_frame_err),
        .hit       (hit),
        .match_q   (st_q.match),
        .first_q   (st_q.first),
        .accept    (accept),
        .flag_addr (flag_addr),
        .flag_first(flag_first),
        .hw_mode   (hw_mode)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = rx_valid && accept;
        if (rx_valid && accept) begin
            st_d.data  = rx_data;
            st_d.aflag = flag_addr;
            st_d.nflag = flag_first;
        end else if (rd_strobe) begin
            st_d.aflag = 1'b0;
            st_d.nflag = 1'b0;
        end
        if (!filt_en) begin
            st_d.match = 1'b0;
            st_d.first = 1'b0;
        end else if (rx_valid && rx_is_addr) begin
            st_d.match = hit;
            st_d.first = hit;
        end else if (rx_valid && accept && hw_mode) begin
            st_d.first = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_pulse      = st_q.irq;
    assign rx_byte        = st_q.data;
    assign is_addr_flag   = st_q.aflag;
    assign new_frame_flag = st_q.nflag;
    assign frame_match    = st_q.match;

    assert_irq_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> !irq_pulse);
    assert_drop_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_pulse |-> $stable(rx_byte));
    assert_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !filt_en) |=> (irq_pulse && !is_addr_flag && !new_frame_flag));
    assert_match_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !filt_en |=> !frame_match);
    assert_data_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && filt_en && filt_mode == 2'b01 && !rx_is_addr) |=> !irq_pulse);
    assert_addr_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && filt_en && filt_mode == 2'b11 && rx_is_addr) |=> !irq_pulse);
    assert_ferr_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && filt_en && filt_mode[1] && !rx_is_addr && rx_frame_err) |=> !irq_pulse);
    assert_nomatch_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && filt_en && filt_mode[1] && !frame_match && !rx_is_addr) |=> !irq_pulse);
    assert_rd_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !rx_valid) |=> (!is_addr_flag && !new_frame_flag));
endmodule

// File: tb/mdrop_filter_test.sv
module mdrop_filter_test;
    localparam int W = 8;
    logic clk = 0, rst_n = 0;
    logic filt_en = 0, rx_valid = 0, rx_is_addr = 0, rx_frame_err = 0, rd_strobe = 0;
    logic [1:0] filt_mode = 0;
    logic [W-1:0] node_addr = 0, rx_data = 0;
    logic irq_pulse, is_addr_flag, new_frame_flag, frame_match;
    logic [W-1:0] rx_byte;
    int checks = 0, errors = 0;
    bit done = 0;

    logic e_irq = 0, e_af = 0, e_nf = 0, e_match = 0, e_first = 0;
    logic [W-1:0] e_byte = 0;
    string tag = "R1";

    always #5 clk = ~clk;

    mdrop_filter #(.DATA_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .filt_en(filt_en), .filt_mode(filt_mode),
        .node_addr(node_addr), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_is_addr(rx_is_addr), .rx_frame_err(rx_frame_err), .rd_strobe(rd_strobe),
        .irq_pulse(irq_pulse), .rx_byte(rx_byte), .is_addr_flag(is_addr_flag),
        .new_frame_flag(new_frame_flag), .frame_match(frame_match)
    );

    task automatic chk(string t, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
        end
    endtask

    task automatic check_all();
        chk(tag, "irq_pulse", irq_pulse, e_irq);
        chk(tag, "rx_byte", rx_byte, e_byte);
        chk(tag, "is_addr_flag", is_addr_flag, e_af);
        chk(tag == "R7" || tag == "R8" ? "R10" : tag, "new_frame_flag", new_frame_flag, e_nf);
        chk("R6", "frame_match", frame_match, e_match);
    endtask

    // expected result of one clock edge, from the requirements
    task automatic model_step();
        logic acc, af, nf, hw, hit;
        hit = (rx_data == node_addr);
        acc = 1; af = 0; nf = 0; hw = 0;
        if (!rx_valid) tag = rd_strobe ? "R11" : "R3";
        else if (!filt_en) tag = "R2";
        if (filt_en) begin
            case (filt_mode)
                2'b00: begin acc = 1; af = rx_is_addr; if (rx_valid) tag = "R4"; end
                2'b01: begin acc = rx_is_addr; af = rx_is_addr; if (rx_valid) tag = "R5"; end
                2'b10: begin
                    hw = 1; acc = rx_is_addr ? hit : (e_match && !rx_frame_err);
                    af = rx_is_addr; nf = !rx_is_addr && e_first;
                    if (rx_valid) tag = (!rx_is_addr && rx_frame_err) ? "R9" : "R7";
                end
                default: begin
                    hw = 1; acc = !rx_is_addr && e_match && !rx_frame_err;
                    nf = !rx_is_addr && e_first;
                    if (rx_valid) tag = (!rx_is_addr && rx_frame_err) ? "R9" : "R8";
                end
            endcase
        end
        e_irq = rx_valid && acc;
        if (rx_valid && acc) begin e_byte = rx_data; e_af = af; e_nf = nf; end
        else if (rd_strobe) begin e_af = 0; e_nf = 0; end
        if (!filt_en) begin e_match = 0; e_first = 0; end
        else if (rx_valid && rx_is_addr) begin e_match = hit; e_first = hit; end
        else if (rx_valid && acc && hw) e_first = 0;
    endtask

    task automatic cyc(logic v, logic [W-1:0] d, logic a, logic fe, logic rd);
        rx_valid = v; rx_data = d; rx_is_addr = a; rx_frame_err = fe; rd_strobe = rd;
        model_step();
        @(negedge clk);
        check_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        tag = "R1";
        check_all();
        rst_n = 1;
        @(negedge clk);
        check_all();
        node_addr = 8'h5A;
        // R2 bypass
        filt_en = 0;
        cyc(1, 8'h11, 1, 0, 0);
        cyc(1, 8'h22, 0, 1, 0);
        // R10 with a framing error on the first data character
        filt_en = 1; filt_mode = 2'b10;
        cyc(1, 8'h5A, 1, 0, 0);
        cyc(1, 8'h33, 0, 1, 0);
        cyc(1, 8'h44, 0, 0, 0);
        cyc(1, 8'h55, 0, 0, 0);
        cyc(0, 8'h00, 0, 0, 1);
        // R7 non-matching frame dropped
        cyc(1, 8'h5B, 1, 0, 0);
        cyc(1, 8'h66, 0, 0, 0);
        // R8 mode 11
        filt_mode = 2'b11;
        cyc(1, 8'h5A, 1, 0, 0);
        cyc(1, 8'h77, 0, 0, 0);
        cyc(1, 8'h78, 0, 0, 1);
        // R5 mode 01
        filt_mode = 2'b01;
        cyc(1, 8'h01, 0, 0, 0);
        cyc(1, 8'h02, 1, 0, 0);
        // random run
        void'($urandom(32'h1234_5678));
        for (int i = 0; i < 4000; i++) begin
            logic [W-1:0] d;
            if ($urandom_range(39) == 0) filt_mode = 2'($urandom_range(3));
            if ($urandom_range(59) == 0) filt_en = ($urandom_range(9) != 0);
            if ($urandom_range(299) == 0) node_addr = W'($urandom);
            d = ($urandom_range(1) == 0) ? node_addr : W'($urandom);
            cyc($urandom_range(9) < 6, d, $urandom_range(3) == 0,
                $urandom_range(6) == 0, $urandom_range(4) == 0);
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(1_500_000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule